// File: doc/BRIEF.md
# Bus-master disk DMA channel controller

This block is the bus-master DMA front end for a parallel disk interface, built as an array of identical channels (two by default). Each channel has a small byte-wide register window holding a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. Software builds a descriptor table, loads its address into the pointer, sets the direction, and then sets the run bit. The channel walks the table one 8-byte entry at a time and copies 32-bit words between the memory port and its own drive data path until the entry flagged as last has been drained.

Completion and faults are reported through the status byte and a per-channel interrupt line. Interrupt and error are cleared by writing one to them. Two bits are plain software scratch flags that record which drive is set up for DMA. The top bit reflects an external simplex strap. All channels share one memory request/grant port, and the lowest-numbered requesting channel takes it.

Top module: `bm_dma_ctrl`

## Requirements
- R1: After reset every register byte of every channel reads 0x00, except status bit 7, which reads the `simplex_in` level.
- R2: Writing the command byte (offset 0) with bit 0 set while bit 0 is clear starts the channel: it copies the pointer and status bit 0 (active) reads 1. Writing bit 0 as 0 stops the channel at once: active clears and neither interrupt nor error is raised.
- R3: Command bit 3 selects the direction: 1 moves drive words into memory and 0 moves memory words to the drive. A write to bit 3 is ignored while bit 0 reads 1.
- R4: A descriptor is two little-endian words at pointer+0 and pointer+4. The first word is the buffer byte address. In the second word, bits 15:0 give the byte count (a multiple of 4; 0 means 65536) and bit 31 marks the last entry. Entries are taken at ascending 8-byte steps.
- R5: When the last word of the last entry has moved, active clears and interrupt (status bit 2) sets, so the low three status bits read 100b. The `irq` output of a channel follows its status bit 2.
- R6: Status bits 2 (interrupt) and 1 (error) clear only when a 1 is written to them, each on its own. Writing 0 to them leaves them unchanged.
- R7: Status bits 5 and 6 read back what was last written to them. Bits 3 and 4 always read 0. Bit 7 is read-only.
- R8: A memory response with `mem_err` set during a descriptor fetch or a data access sets error and interrupt, clears active, and ends the walk.
- R9: Channel n occupies register offsets 8n to 8n+7. Each channel's registers, walk and interrupt are independent of every other channel.
- R10: The shared memory request stays asserted until granted. At most one channel is granted per cycle, and the lowest-numbered requesting channel wins.
- R11: Data words move in order at consecutive word addresses starting at the buffer address. The pointer bytes at offsets 4 to 7 map to pointer bits 7:0 up to 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | RA_W (4) | Register byte address; bits above 2 select the channel |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| simplex_in | input | 1 | Simplex strap shown in status bit 7 |
| irq | output | NUM_CH | Per-channel interrupt (status bit 2) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access performed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| mem_err | input | 1 | Access failed, valid with `mem_gnt` |
| drv_rd_valid | input | NUM_CH | Drive offers a word (drive-to-memory) |
| drv_rd_data | input | 32*NUM_CH | Offered drive words, channel n at bits 32n+31:32n |
| drv_rd_ack | output | NUM_CH | Channel takes the offered word |
| drv_wr_valid | output | NUM_CH | Channel presents a word to the drive |
| drv_wr_data | output | 32*NUM_CH | Presented words, channel n at bits 32n+31:32n |
| drv_wr_ready | input | NUM_CH | Drive accepts the presented word |

## Verification
The bench targets the zero byte count, which has to run for 16384 words. A design that read it as zero would finish at once, and one that truncated it would stop early. A stall test stops a run that is parked on a silent drive and tries to change direction mid-run. A wrong design would raise a spurious interrupt, leave active set, or flip direction while data is moving. Faults on a descriptor fetch and on a data write must both end with status 0x06, and the two write-one-to-clear bits are cleared one at a time to catch clearing the pair together. A two-entry chain under a throttled grant, and a run on the second channel, catch a walk that skips or repeats entries and any register or interrupt leaking between channels.

// File: rtl/bm_dma_pkg.sv
// Shared constants and types for the bus-master DMA channel controller.
package bm_dma_pkg;
    localparam int WORD_W    = 32;   // memory and drive word width
    localparam int REG_W     = 8;    // register byte width
    localparam int CNT_W     = 16;   // byte-count field width in a descriptor
    localparam int LAST_BIT  = 31;   // end-of-table flag in the control word
    localparam int RUN_BIT   = 0;    // command: run / stop
    localparam int DIR_BIT   = 3;    // command: 1 = drive to memory
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_DESC_ADDR,
        ENG_DESC_CTL,
        ENG_GET,
        ENG_PUT
    } eng_state_t;
endpackage

// File: rtl/bm_dma_chan_regs.sv
// Per-channel register byte window: command, status and table pointer.
// Assumes wr_en is already qualified by channel select; reads are combinational.
module bm_dma_chan_regs
    import bm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        offs,
    input  logic [REG_W-1:0]  wdata,
    input  logic              simplex,
    input  logic              busy,
    input  logic              done,
    input  logic              fault,
    output logic [REG_W-1:0]  rdata,
    output logic              go,
    output logic              halt,
    output logic              to_mem,
    output logic [WORD_W-1:0] tbl_base,
    output logic              irq
);
    logic       run_q;
    logic       err_q;
    logic       irq_q;
    logic [1:0] cap_q;
    logic       wr_cmd;
    logic       wr_stat;

    assign wr_cmd  = wr_en && (offs == OFF_CMD);
    assign wr_stat = wr_en && (offs == OFF_STAT);
    assign go      = wr_cmd && wdata[RUN_BIT] && !run_q;
    assign halt    = wr_cmd && !wdata[RUN_BIT];
    assign irq     = irq_q;

    // Command byte: run bit always writable, direction only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            to_mem <= 1'b0;
        end else if (wr_cmd) begin
            run_q <= wdata[RUN_BIT];
            if (!run_q) to_mem <= wdata[DIR_BIT];
        end
    end

    // Status byte: engine events set flags, a written one clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b00;
        end else begin
            err_q <= fault | (err_q & ~(wr_stat & wdata[1]));
            irq_q <= done | fault | (irq_q & ~(wr_stat & wdata[2]));
            if (wr_stat) cap_q <= wdata[6:5];
        end
    end

    // Table pointer: four byte lanes, least significant at offset 4.
    always_ff @(posedge clk) begin
        if (!rst_n) tbl_base <= '0;
        else if (wr_en && offs[2]) tbl_base[offs[1:0]*8 +: 8] <= wdata;
    end

    // Read mux for the channel window.
    always_comb begin
        case (offs)
            OFF_CMD:  rdata = {4'b0, to_mem, 2'b0, run_q};
            OFF_STAT: rdata = {simplex, cap_q, 2'b0, irq_q, err_q, busy};
            3'd4, 3'd5, 3'd6, 3'd7: rdata = tbl_base[offs[1:0]*8 +: 8];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bm_dma_walk_engine.sv
// Descriptor walker and word mover for one channel.
// Assumes single-beat memory accesses completed by mem_gnt (with mem_rdata and
// mem_err valid in that cycle) and byte counts that are multiples of four.
module bm_dma_walk_engine
    import bm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic              to_mem,
    input  logic [WORD_W-1:0] tbl_base,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  logic              drv_rd_valid,
    input  logic [WORD_W-1:0] drv_rd_data,
    output logic              drv_rd_ack,
    output logic              drv_wr_valid,
    output logic [WORD_W-1:0] drv_wr_data,
    input  logic              drv_wr_ready
);
    localparam int WCNT_W = CNT_W - 1;   // words per entry, up to 2**(CNT_W-2)
    localparam int FLD_W  = CNT_W - 2;   // word-count part of the byte field

    eng_state_t        state;
    logic              dir_q;
    logic              last_q;
    logic [WORD_W-1:0] walk_q;
    logic [WORD_W-1:0] buf_q;
    logic [WORD_W-1:0] hold_q;
    logic [WCNT_W-1:0] words_q;
    logic [FLD_W-1:0]  fld;
    logic              put_step;
    logic              get_step;

    assign fld      = mem_rdata[CNT_W-1:2];
    assign busy     = (state != ENG_IDLE);
    assign mem_req  = (state == ENG_DESC_ADDR) || (state == ENG_DESC_CTL) ||
                      ((state == ENG_GET) && !dir_q) || ((state == ENG_PUT) && dir_q);
    assign mem_we   = (state == ENG_PUT) && dir_q;
    assign mem_wdata = hold_q;
    assign drv_rd_ack   = (state == ENG_GET) && dir_q && drv_rd_valid;
    assign drv_wr_valid = (state == ENG_PUT) && !dir_q;
    assign drv_wr_data  = hold_q;
    assign get_step = dir_q ? drv_rd_valid : mem_gnt;
    assign put_step = dir_q ? mem_gnt : drv_wr_ready;
    assign fault    = !halt && mem_req && mem_gnt && mem_err;
    assign done     = !halt && (state == ENG_PUT) && put_step && !fault &&
                      last_q && (words_q == WCNT_W'(1));

    // Address of the current memory access.
    always_comb begin
        case (state)
            ENG_DESC_ADDR: mem_addr = walk_q;
            ENG_DESC_CTL:  mem_addr = walk_q + WORD_W'(4);
            default:       mem_addr = buf_q;
        endcase
    end

    // Walk sequencer: fetch entry, then alternate get/put until drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            dir_q   <= 1'b0;
            last_q  <= 1'b0;
            walk_q  <= '0;
            buf_q   <= '0;
            hold_q  <= '0;
            words_q <= '0;
        end else if (halt || fault) begin
            state <= ENG_IDLE;
        end else begin
            case (state)
                ENG_IDLE: if (go) begin
                    walk_q <= tbl_base;
                    dir_q  <= to_mem;
                    state  <= ENG_DESC_ADDR;
                end
                ENG_DESC_ADDR: if (mem_gnt) begin
                    buf_q <= mem_rdata;
                    state <= ENG_DESC_CTL;
                end
                ENG_DESC_CTL: if (mem_gnt) begin
                    words_q <= (fld == '0) ? (WCNT_W'(1) << FLD_W) : WCNT_W'(fld);
                    last_q  <= mem_rdata[LAST_BIT];
                    walk_q  <= walk_q + WORD_W'(8);
                    state   <= ENG_GET;
                end
                ENG_GET: if (get_step) begin
                    hold_q <= dir_q ? drv_rd_data : mem_rdata;
                    state  <= ENG_PUT;
                end
                ENG_PUT: if (put_step) begin
                    buf_q   <= buf_q + WORD_W'(4);
                    words_q <= words_q - WCNT_W'(1);
                    if (words_q != WCNT_W'(1)) state <= ENG_GET;
                    else if (last_q)           state <= ENG_IDLE;
                    else                       state <= ENG_DESC_ADDR;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bm_dma_mem_arb.sv
// Fixed-priority merge of per-channel memory requests onto one port.
// Assumes single-cycle accesses, so no grant lock is needed between beats.
module bm_dma_mem_arb
    import bm_dma_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH-1:0]        ch_we,
    input  logic [NUM_CH*WORD_W-1:0] ch_addr,
    input  logic [NUM_CH*WORD_W-1:0] ch_wdata,
    output logic [NUM_CH-1:0]        ch_gnt,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [WORD_W-1:0]        mem_addr,
    output logic [WORD_W-1:0]        mem_wdata,
    input  logic                     mem_gnt
);
    logic found;

    // Lowest-numbered requester owns the port this cycle.
    always_comb begin
        found     = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ch_gnt    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_req[i] && !found) begin
                found     = 1'b1;
                mem_we    = ch_we[i];
                mem_addr  = ch_addr[i*WORD_W +: WORD_W];
                mem_wdata = ch_wdata[i*WORD_W +: WORD_W];
                ch_gnt[i] = mem_gnt;
            end
        end
        mem_req = found;
    end
endmodule

// File: rtl/bm_dma_ctrl.sv
// Multi-channel bus-master DMA controller: register windows 8 bytes apart,
// one walk engine per channel, shared memory port.
// Assumes NUM_CH >= 1; unused window addresses read as zero.
module bm_dma_ctrl
    import bm_dma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W  = 3 + CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic                     simplex_in,
    output logic [NUM_CH-1:0]        irq,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [WORD_W-1:0]        mem_addr,
    output logic [WORD_W-1:0]        mem_wdata,
    input  logic                     mem_gnt,
    input  logic [WORD_W-1:0]        mem_rdata,
    input  logic                     mem_err,
    input  logic [NUM_CH-1:0]        drv_rd_valid,
    input  logic [NUM_CH*WORD_W-1:0] drv_rd_data,
    output logic [NUM_CH-1:0]        drv_rd_ack,
    output logic [NUM_CH-1:0]        drv_wr_valid,
    output logic [NUM_CH*WORD_W-1:0] drv_wr_data,
    input  logic [NUM_CH-1:0]        drv_wr_ready
);
    logic [CH_W-1:0]          ch_sel;
    logic [REG_W-1:0]         ch_rdata [NUM_CH];
    logic [NUM_CH-1:0]        ch_busy, ch_done, ch_fault, ch_go, ch_halt, ch_to_mem;
    logic [NUM_CH-1:0]        ch_req, ch_we, ch_gnt;
    logic [NUM_CH*WORD_W-1:0] ch_addr, ch_wdata;
    logic [WORD_W-1:0]        ch_base [NUM_CH];

    assign ch_sel = reg_addr[RA_W-1:3];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bm_dma_chan_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && (ch_sel == CH_W'(c))),
            .offs     (reg_addr[2:0]),
            .wdata    (reg_wdata),
            .simplex  (simplex_in),
            .busy     (ch_busy[c]),
            .done     (ch_done[c]),
            .fault    (ch_fault[c]),
            .rdata    (ch_rdata[c]),
            .go       (ch_go[c]),
            .halt     (ch_halt[c]),
            .to_mem   (ch_to_mem[c]),
            .tbl_base (ch_base[c]),
            .irq      (irq[c])
        );

        bm_dma_walk_engine u_eng (
            .clk          (clk),
            .rst_n        (rst_n),
            .go           (ch_go[c]),
            .halt         (ch_halt[c]),
            .to_mem       (ch_to_mem[c]),
            .tbl_base     (ch_base[c]),
            .busy         (ch_busy[c]),
            .done         (ch_done[c]),
            .fault        (ch_fault[c]),
            .mem_req      (ch_req[c]),
            .mem_we       (ch_we[c]),
            .mem_addr     (ch_addr[c*WORD_W +: WORD_W]),
            .mem_wdata    (ch_wdata[c*WORD_W +: WORD_W]),
            .mem_gnt      (ch_gnt[c]),
            .mem_rdata    (mem_rdata),
            .mem_err      (mem_err),
            .drv_rd_valid (drv_rd_valid[c]),
            .drv_rd_data  (drv_rd_data[c*WORD_W +: WORD_W]),
            .drv_rd_ack   (drv_rd_ack[c]),
            .drv_wr_valid (drv_wr_valid[c]),
            .drv_wr_data  (drv_wr_data[c*WORD_W +: WORD_W]),
            .drv_wr_ready (drv_wr_ready[c])
        );
    end

    // Window read: selected channel, zero outside the populated range.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_sel == CH_W'(i)) reg_rdata = ch_rdata[i];
    end

    bm_dma_mem_arb #(.NUM_CH(NUM_CH)) u_arb (
        .ch_req    (ch_req),
        .ch_we     (ch_we),
        .ch_addr   (ch_addr),
        .ch_wdata  (ch_wdata),
        .ch_gnt    (ch_gnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt)
    );
endmodule

// File: rtl/bm_dma_ctrl_checker.sv
// Temporal checks on the controller, attached to every bm_dma_ctrl instance.
module bm_dma_ctrl_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [NUM_CH-1:0] ch_gnt,
    input logic [NUM_CH-1:0] ch_busy,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_fault,
    input logic [NUM_CH-1:0] ch_to_mem,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] drv_rd_ack,
    input logic [NUM_CH-1:0] drv_wr_valid
);
    assert_dir_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_busy[0] |=> $stable(ch_to_mem[0]));

    assert_done_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_done[0] |=> (irq[0] && !ch_busy[0]));

    assert_fault_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_fault[0] |=> (irq[0] && !ch_busy[0]));

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_gnt));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !reg_wr) |=> mem_req);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_busy[0] |-> (!drv_rd_ack[0] && !drv_wr_valid[0]));
endmodule

bind bm_dma_ctrl bm_dma_ctrl_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .ch_gnt       (ch_gnt),
    .ch_busy      (ch_busy),
    .ch_done      (ch_done),
    .ch_fault     (ch_fault),
    .ch_to_mem    (ch_to_mem),
    .irq          (irq),
    .drv_rd_ack   (drv_rd_ack),
    .drv_wr_valid (drv_wr_valid)
);

// File: tb/bm_dma_ctrl_bench.sv
`timescale 1ns/100ps
module bm_dma_ctrl_bench;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        simplex_in = 1'b0;
    logic [1:0]  irq;
    logic        mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  drv_rd_valid = 2'b11;
    logic [63:0] drv_rd_data;
    logic [1:0]  drv_rd_ack, drv_wr_valid;
    logic [63:0] drv_wr_data;
    logic [1:0]  drv_wr_ready = 2'b11;

    logic [31:0] mem [0:1023];
    logic [31:0] src_cnt [2];
    logic [31:0] sink_log [32];
    logic [31:0] sink_cnt;
    logic        slow_mem = 1'b0;
    logic        tick;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    bm_dma_ctrl u_bm_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .simplex_in(simplex_in),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .drv_rd_valid(drv_rd_valid), .drv_rd_data(drv_rd_data),
        .drv_rd_ack(drv_rd_ack), .drv_wr_valid(drv_wr_valid),
        .drv_wr_data(drv_wr_data), .drv_wr_ready(drv_wr_ready)
    );

    // Memory model: single-cycle, optionally granting every other cycle.
    assign mem_gnt   = mem_req && (!slow_mem || tick);
    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_err   = mem_req && (mem_addr == err_addr);
    assign drv_rd_data = {32'hB100_0000 + src_cnt[1], 32'hA000_0000 + src_cnt[0]};

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tick <= (cyc % 2) == 0;
        if (mem_req && mem_gnt && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        if (!rst_n) begin
            src_cnt[0] <= 0; src_cnt[1] <= 0; sink_cnt <= 0;
        end else begin
            for (int c = 0; c < 2; c++) if (drv_rd_ack[c]) src_cnt[c] <= src_cnt[c] + 1;
            if (drv_wr_valid[0] && drv_wr_ready[0]) begin
                sink_log[sink_cnt[4:0]] <= drv_wr_data[31:0];
                sink_cnt <= sink_cnt + 1;
            end
        end
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R5 watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'(ch*8 + off); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'(ch*8 + off);
        #1 d = reg_rdata;
    endtask

    task automatic set_ptr(input int ch, input logic [31:0] p);
        for (int b = 0; b < 4; b++) wr(ch, 4 + b, p[b*8 +: 8]);
    endtask

    task automatic start(input int ch, input logic dir);
        wr(ch, 0, {4'b0, dir, 3'b0});
        wr(ch, 0, {4'b0, dir, 3'b1});
    endtask

    task automatic wait_idle(input int ch, input int limit);
        logic [7:0] s;
        for (int i = 0; i < limit; i++) begin
            rd(ch, 2, s);
            if (!s[0]) break;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int ch = 0; ch < 2; ch++)
            for (int off = 0; off < 8; off++) begin
                rd(ch, off, v);
                chk("R1 reset value", {24'b0, v}, 32'h0);
            end
        chk("R1 irq after reset", {30'b0, irq}, 32'h0);
    endtask

    task automatic t_to_mem;
        logic [7:0] v;
        logic [31:0] base = src_cnt[0];
        mem[32'h100 >> 2] = 32'h400;
        mem[32'h104 >> 2] = 32'h8000_0010;
        set_ptr(0, 32'h100);
        rd(0, 5, v);
        chk("R11 pointer byte lane", {24'b0, v}, 32'h01);
        start(0, 1'b1);
        wait_idle(0, 200);
        for (int i = 0; i < 4; i++)
            chk("R11 to-memory word order", mem[(32'h400 >> 2) + i], 32'hA000_0000 + base + i);
        rd(0, 2, v);
        chk("R5 status after clean run", {24'b0, v}, 32'h04);
        chk("R5 irq line", {30'b0, irq}, 32'h1);
        wr(0, 2, 8'h00);
        rd(0, 2, v);
        chk("R6 writing zero keeps irq", {24'b0, v}, 32'h04);
        wr(0, 2, 8'h04);
        rd(0, 2, v);
        chk("R6 irq cleared by one", {24'b0, v}, 32'h00);
        wr(0, 0, 8'h00);
    endtask

    task automatic t_chain_from_mem;
        logic [7:0] v;
        logic [31:0] n0 = sink_cnt;
        logic [31:0] exp [5];
        mem[32'h180 >> 2] = 32'h600;  mem[32'h184 >> 2] = 32'h0000_0008;
        mem[32'h188 >> 2] = 32'h700;  mem[32'h18C >> 2] = 32'h8000_000C;
        for (int i = 0; i < 2; i++) begin
            mem[(32'h600 >> 2) + i] = 32'hC0DE_0000 + i;
            exp[i] = 32'hC0DE_0000 + i;
        end
        for (int i = 0; i < 3; i++) begin
            mem[(32'h700 >> 2) + i] = 32'hC0DE_0100 + i;
            exp[2 + i] = 32'hC0DE_0100 + i;
        end
        slow_mem = 1'b1;
        set_ptr(0, 32'h180);
        start(0, 1'b0);
        wait_idle(0, 400);
        slow_mem = 1'b0;
        chk("R4 chained word count", sink_cnt - n0, 32'd5);
        for (int i = 0; i < 5; i++)
            chk("R4 chained data order", sink_log[5'(n0 + i)], exp[i]);
        rd(0, 2, v);
        chk("R5 chain status", {24'b0, v}, 32'h04);
        wr(0, 2, 8'h06);
        wr(0, 0, 8'h00);
    endtask

    task automatic t_zero_count;
        logic [7:0] v;
        logic [31:0] base = src_cnt[0];
        mem[32'h200 >> 2] = 32'h0;
        mem[32'h204 >> 2] = 32'h8000_0000;
        set_ptr(0, 32'h200);
        start(0, 1'b1);
        wait_idle(0, 40000);
        chk("R4 zero count moves 16384 words", src_cnt[0] - base, 32'd16384);
        chk("R4 zero count final word", mem[1023], 32'hA000_0000 + base + 16383);
        rd(0, 2, v);
        chk("R5 zero count status", {24'b0, v}, 32'h04);
        wr(0, 2, 8'h04);
        wr(0, 0, 8'h00);
    endtask

    task automatic t_stop_and_dir_lock;
        logic [7:0] v;
        logic [31:0] base = src_cnt[0];
        mem[32'h280 >> 2] = 32'h500;
        mem[32'h284 >> 2] = 32'h8000_0010;
        drv_rd_valid[0] = 1'b0;
        set_ptr(0, 32'h280);
        start(0, 1'b1);
        repeat (6) @(negedge clk);
        rd(0, 2, v);
        chk("R2 active while parked", {24'b0, v}, 32'h01);
        wr(0, 0, 8'h01);
        rd(0, 0, v);
        chk("R3 direction write ignored while running", {24'b0, v}, 32'h09);
        wr(0, 0, 8'h08);
        rd(0, 2, v);
        chk("R2 stop clears active, no irq", {24'b0, v}, 32'h00);
        chk("R2 irq low after stop", {30'b0, irq}, 32'h0);
        drv_rd_valid[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 no words taken after stop", src_cnt[0] - base, 32'd0);
        wr(0, 0, 8'h00);
        rd(0, 0, v);
        chk("R3 direction writable when stopped", {24'b0, v}, 32'h00);
    endtask

    task automatic t_faults;
        logic [7:0] v;
        err_addr = 32'h900;
        mem[32'h100 >> 2] = 32'h900;
        mem[32'h104 >> 2] = 32'h8000_0010;
        set_ptr(0, 32'h100);
        start(0, 1'b1);
        wait_idle(0, 100);
        rd(0, 2, v);
        chk("R8 data write fault status", {24'b0, v}, 32'h06);
        wr(0, 2, 8'h02);
        rd(0, 2, v);
        chk("R6 error cleared alone", {24'b0, v}, 32'h04);
        wr(0, 2, 8'h04);
        wr(0, 0, 8'h00);
        set_ptr(0, 32'h900);
        start(0, 1'b0);
        wait_idle(0, 100);
        rd(0, 2, v);
        chk("R8 descriptor fetch fault status", {24'b0, v}, 32'h06);
        chk("R8 fault raises irq line", {30'b0, irq}, 32'h1);
        wr(0, 2, 8'h06);
        wr(0, 0, 8'h00);
        err_addr = 32'hFFFF_FFF0;
    endtask

    task automatic t_flags;
        logic [7:0] v;
        wr(0, 2, 8'hF8);
        rd(0, 2, v);
        chk("R7 capable bits stored, bits 3/4/7 not", {24'b0, v}, 32'h60);
        simplex_in = 1'b1;
        rd(1, 2, v);
        chk("R7 simplex bit follows strap", {24'b0, v}, 32'h80);
        simplex_in = 1'b0;
        wr(0, 2, 8'h00);
        rd(0, 2, v);
        chk("R7 capable bits cleared", {24'b0, v}, 32'h00);
    endtask

    task automatic t_second_channel;
        logic [7:0] v;
        logic [31:0] base = src_cnt[1];
        mem[32'h300 >> 2] = 32'h800;
        mem[32'h304 >> 2] = 32'h8000_0008;
        set_ptr(1, 32'h300);
        rd(0, 4, v);
        chk("R9 channel 0 pointer untouched", {24'b0, v}, 32'h00);
        start(1, 1'b1);
        wait_idle(1, 200);
        chk("R9 channel 1 data word 0", mem[32'h800 >> 2], 32'hB100_0000 + base);
        chk("R9 channel 1 data word 1", mem[(32'h800 >> 2) + 1], 32'hB100_0000 + base + 1);
        rd(1, 2, v);
        chk("R9 channel 1 status", {24'b0, v}, 32'h04);
        rd(0, 2, v);
        chk("R9 channel 0 status untouched", {24'b0, v}, 32'h00);
        chk("R9 irq only on channel 1", {30'b0, irq}, 32'h2);
        wr(1, 2, 8'h04);
        wr(1, 0, 8'h00);
    endtask

    task automatic t_both_channels;
        logic [7:0] v;
        logic [31:0] b0 = src_cnt[0];
        logic [31:0] b1 = src_cnt[1];
        mem[32'h100 >> 2] = 32'h400; mem[32'h104 >> 2] = 32'h8000_0010;
        mem[32'h300 >> 2] = 32'h800; mem[32'h304 >> 2] = 32'h8000_0010;
        set_ptr(0, 32'h100);
        start(1, 1'b1);
        start(0, 1'b1);
        wait_idle(0, 200);
        wait_idle(1, 200);
        chk("R10 shared port channel 0 last word", mem[(32'h400 >> 2) + 3], 32'hA000_0000 + b0 + 3);
        chk("R10 shared port channel 1 last word", mem[(32'h800 >> 2) + 3], 32'hB100_0000 + b1 + 3);
        chk("R10 both channels complete", {30'b0, irq}, 32'h3);
        wr(0, 2, 8'h04); wr(1, 2, 8'h04);
        wr(0, 0, 8'h00); wr(1, 0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_to_mem();
        t_chain_from_mem();
        t_stop_and_dir_lock();
        t_faults();
        t_flags();
        t_second_channel();
        t_both_channels();
        t_zero_count();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule